// File: doc/BRIEF.md
# Crosswise Column-Sum Unsigned Multiplier

This block is a purely combinational unsigned multiplier. It builds the product one result column at a time. For column k it takes every single-bit product `mcand[i] & mplier[j]` with `i + j == k` and counts them together with the carry from column k-1. The low bit of that count becomes result bit k. The higher bits pass to column k+1 as its carry. No product wider than one bit is ever formed: after the AND gates everything is addition. The carry out of the last column with products becomes the most significant result bit. Only that final column may produce more than one result digit.

The two operand widths are independent parameters. A typical use is to multiply an 8-bit square by its 4-bit root, which gives a cube. A generate option picks how each column's count is built: either one linear count, or two half-column counts that are then added. Both options give identical results.

Top module: `cw_mul`

## Requirements
- R1: `prod` is WA+WB bits wide and equals the unsigned product `mcand * mplier` for every operand pair. In the default 8x4 configuration all 4096 pairs are covered.
- R2: `prod[0]` equals `mcand[0] & mplier[0]`, the vertical product of the two least significant bits.
- R3: `prod[1]` equals `(mcand[1] & mplier[0]) ^ (mcand[0] & mplier[1])`. Column 0 never produces a carry.
- R4: Unequal and wider operand widths give the exact product, for example WA=16 with WB=12.
- R5: If either operand is zero, `prod` is zero.
- R6: When `mplier` is 1, `prod` equals `mcand` zero-extended to WA+WB bits.
- R7: With all-ones operands `prod` is (2^WA-1)(2^WB-1). No column's carry exceeds min(WA,WB). The carry leaving the last column is at most 1.
- R8: In an 8x8 configuration, 153 x 135 gives 20655.
- R9: With the two-half column count selected (COL_SPLIT=1), every product equals the one obtained with the linear count.
- R10: Feeding an 8-bit square x*x as `mcand` and x as the 4-bit `mplier` gives x^3, for x from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | WA | Unsigned multiplicand |
| mplier | input | WB | Unsigned multiplier |
| prod | output | WA+WB | Unsigned product |

## Verification
The block holds no state, so any internal fault appears at `prod` in the same cycle that the operands that trigger it are applied. A column that counts the wrong set of crosswise products shows up as a wrong bit at or above that column's position. A carry that is dropped or too narrow corrupts the upper bits, and only for operands with dense one bits. For this reason the all-ones corner case and the exhaustive 8x4 sweep matter most. A carry that leaks out of column 0 would make bit 1 differ from the XOR of the two lowest cross products.

// File: rtl/cw_mul_pkg.sv
package cw_mul_pkg;

   function automatic int cw_min2(input int x, input int y);
      return (x < y) ? x : y;
   endfunction

   function automatic int cw_max2(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   // lowest multiplicand index that meets column k
   function automatic int cw_col_lo(input int k, input int wb);
      return cw_max2(0, k - wb + 1);
   endfunction

   // number of single-bit products falling into column k
   function automatic int cw_col_terms(input int k, input int wa, input int wb);
      int lo;
      int hi;
      lo = cw_col_lo(k, wb);
      hi = cw_min2(k, wa - 1);
      return (hi >= lo) ? (hi - lo + 1) : 0;
   endfunction

   // width of a column sum: at most m products plus a carry bounded by m
   function automatic int cw_sum_w(input int m);
      return $clog2(2 * m + 1);
   endfunction

endpackage

// File: rtl/cw_col_terms.sv
module cw_col_terms
   import cw_mul_pkg::*;
#(
   parameter int WA = 8,
   parameter int WB = 4,
   parameter int K  = 0,
   parameter int NT = 1
) (
   input  logic [WA-1:0] mcand,
   input  logic [WB-1:0] mplier,
   output logic [NT-1:0] terms
);
   localparam int LO = cw_col_lo(K, WB);

   if (NT != cw_col_terms(K, WA, WB)) begin : g_bad_nt
      $error("cw_col_terms: NT does not match column %0d", K);
   end

   for (genvar n = 0; n < NT; n++) begin : g_term
      localparam int IA = LO + n;
      localparam int IB = K - IA;
      assign terms[n] = mcand[IA] & mplier[IB];
   end

endmodule

// File: rtl/cw_col_adder.sv
module cw_col_adder #(
   parameter int NT        = 1,
   parameter int CW        = 2,
   parameter int MAXC      = 1,
   parameter bit COL_SPLIT = 1'b0
) (
   input  logic [NT-1:0] terms,
   input  logic [CW-1:0] cin,
   output logic          digit,
   output logic [CW-1:0] cout
);
   localparam int SW = CW + 1;
   localparam int NL = NT / 2;
   localparam int NH = NT - NL;

   logic [SW-1:0] total;

   if (CW < 1) begin : g_bad_cw
      $error("cw_col_adder: carry width must be at least 1");
   end

   if (!COL_SPLIT || NT < 2) begin : g_linear
      always_comb begin
         total = SW'(cin);
         for (int n = 0; n < NT; n++) begin
            total = total + SW'(terms[n]);
         end
      end
   end else begin : g_split
      logic [SW-1:0] cnt_lo;
      logic [SW-1:0] cnt_hi;
      always_comb begin
         cnt_lo = '0;
         for (int n = 0; n < NL; n++) begin
            cnt_lo = cnt_lo + SW'(terms[n]);
         end
      end
      always_comb begin
         cnt_hi = SW'(cin);
         for (int n = NL; n < NL + NH; n++) begin
            cnt_hi = cnt_hi + SW'(terms[n]);
         end
      end
      assign total = cnt_lo + cnt_hi;
   end

   assign digit = total[0];
   assign cout  = total[SW-1:1];

   always_comb begin
      if (int'(cin) <= MAXC) begin
         AST_CARRY_BOUND: assert (int'(cout) <= MAXC); // R7
      end
   end

endmodule

// File: rtl/cw_mul.sv
module cw_mul
   import cw_mul_pkg::*;
#(
   parameter int WA        = 8,
   parameter int WB        = 4,
   parameter bit COL_SPLIT = 1'b0
) (
   input  logic [WA-1:0]    mcand,
   input  logic [WB-1:0]    mplier,
   output logic [WA+WB-1:0] prod
);
   localparam int WP   = WA + WB;
   localparam int NCOL = WP - 1;
   localparam int M    = cw_min2(WA, WB);
   localparam int SW   = cw_sum_w(M);
   localparam int CW   = SW - 1;

   if (WA < 2 || WB < 2) begin : g_bad_width
      $error("cw_mul: both operand widths must be at least 2");
   end

   logic [CW-1:0] carry [NCOL+1];
   assign carry[0] = '0;

   for (genvar k = 0; k < NCOL; k++) begin : g_col
      localparam int NT = cw_col_terms(k, WA, WB);
      logic [NT-1:0] terms;
      logic          dig;

      cw_col_terms #(
         .WA(WA), .WB(WB), .K(k), .NT(NT)
      ) u_terms (
         .mcand (mcand),
         .mplier(mplier),
         .terms (terms)
      );

      cw_col_adder #(
         .NT(NT), .CW(CW), .MAXC(M), .COL_SPLIT(COL_SPLIT)
      ) u_add (
         .terms(terms),
         .cin  (carry[k]),
         .digit(dig),
         .cout (carry[k+1])
      );

      assign prod[k] = dig;
   end

   assign prod[WP-1] = carry[NCOL][0];

   always_comb begin
      AST_TOP_CARRY: assert (int'(carry[NCOL]) <= 1); // R7
      AST_LSB_VERTICAL: assert (prod[0] == (mcand[0] & mplier[0])); // R2
      if (mcand == '0 || mplier == '0) begin
         AST_ZERO_OPERAND: assert (prod == '0); // R5
      end
      if (mplier == WB'(1)) begin
         AST_UNIT_MPLIER: assert (prod == WP'(mcand)); // R6
      end
   end

endmodule

// File: tb/sim_cw_mul.sv
`timescale 1ns/1ps
module sim_cw_mul;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // default 8x4
   logic [7:0]  a0;
   logic [3:0]  b0;
   logic [11:0] p0;
   // wide unequal 16x12
   logic [15:0] a1;
   logic [11:0] b1;
   logic [27:0] p1;
   // 8x8, split column count
   logic [7:0]  a2;
   logic [7:0]  b2;
   logic [15:0] p2;
   // 8x8, linear column count
   logic [15:0] p3;

   cw_mul #(.WA(8),  .WB(4),  .COL_SPLIT(1'b0)) u0 (.mcand(a0), .mplier(b0), .prod(p0));
   cw_mul #(.WA(16), .WB(12), .COL_SPLIT(1'b0)) u1 (.mcand(a1), .mplier(b1), .prod(p1));
   cw_mul #(.WA(8),  .WB(8),  .COL_SPLIT(1'b1)) u2 (.mcand(a2), .mplier(b2), .prod(p2));
   cw_mul #(.WA(8),  .WB(8),  .COL_SPLIT(1'b0)) u3 (.mcand(a2), .mplier(b2), .prod(p3));

   task automatic check(input string req, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply0(input int x, input int y);
      @(posedge clk);
      a0 = 8'(x);
      b0 = 4'(y);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin : main
      a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5: quiescent zero operands
      check("R5", p0, 0);
      check("R5", p1, 0);
      check("R5", p2, 0);

      // R1 R2 R3 R5 R6: exhaustive 8x4
      for (int x = 0; x < 256; x++) begin
         for (int y = 0; y < 16; y++) begin
            apply0(x, y);
            check("R1", p0, longint'(x) * longint'(y));
            check("R2", p0[0], (x & y) & 1);
            check("R3", p0[1], (((x >> 1) & y) ^ (x & (y >> 1))) & 1);
            if (x == 0 || y == 0) check("R5", p0, 0);
            if (y == 1) check("R6", p0, x);
         end
      end

      // R7: all ones on every configuration
      apply0(255, 15);
      check("R7", p0, 255 * 15);
      @(posedge clk);
      a1 = 16'hFFFF; b1 = 12'hFFF; a2 = 8'hFF; b2 = 8'hFF;
      @(negedge clk);
      check("R7", p1, longint'(65535) * longint'(4095));
      check("R7", p2, 255 * 255);
      check("R9", p2, p3);

      // R8: decimal worked example
      @(posedge clk);
      a2 = 8'd153; b2 = 8'd135;
      @(negedge clk);
      check("R8", p2, 20655);
      check("R8", p3, 20655);

      // R10: square times root gives cube
      for (int x = 0; x < 16; x++) begin
         apply0(x * x, x);
         check("R10", p0, longint'(x) * x * x);
      end

      // R4 R9: random wide and 8x8 operands
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] ra;
         logic [11:0] rb;
         logic [7:0]  rc;
         logic [7:0]  rd;
         ra = 16'($urandom);
         rb = 12'($urandom);
         rc = 8'($urandom);
         rd = 8'($urandom);
         if (n % 10 == 0) rb = 12'h001;
         @(posedge clk);
         a1 = ra; b1 = rb; a2 = rc; b2 = rd;
         @(negedge clk);
         check("R4", p1, longint'(ra) * longint'(rb));
         check("R9", p2, longint'(rc) * longint'(rd));
         check("R9", p2, p3);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule